// File: doc/BRIEF.md
# Floating-Point Store Data Converter

This block sits on the store path of a load/store unit. It takes a floating-point operand from the register file, always held in the 64-bit double layout, and turns it into the bytes that memory receives. The operand comes with a tag that says whether its value fits the single format exactly, and with a store-kind bit that selects a 32-bit single store or a 64-bit double store.

The block sorts the operand into one of six classes: zero, denormal, normal, infinity, quiet NaN and signalling NaN. It then applies the action that fits the class, the tag and the store kind. The result leaves through one register stage.

Both streams use a valid/ready handshake. A transfer takes place on a rising clock edge when valid and ready are both high. The input is ready whenever the output register is empty or is being drained in the same cycle. A stalled result keeps its data and kind bit stable until it is taken. With the output ready held high, one operand can enter on every cycle.

Register convention for single-tagged operands: a single-tagged denormal is held with exponent field 0, and its 23 significant fraction bits sit in register bits 51..29. Every other single-tagged value is held as the equal double value.

Top module: `fp_store_fmt`

## Requirements
- R1: While `rst` is high, and on the first edge after it, `out_valid` is low. `in_ready` is high once `rst` has dropped and the output is empty.
- R2: An operand accepted on edge N appears on `out_valid`/`out_data` after edge N. While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_data`/`out_dbl` hold steady. Operands accepted on consecutive edges each give a result.
- R3: On a single store of a single-tagged operand, the following rules apply, and a signalling NaN is not quieted:
  - the sign is kept in bit 31;
  - a normal gets its exponent rebiased by subtracting 896;
  - a denormal gets exponent 0;
  - a zero gets exponent 0 and fraction 0;
  - an infinity or NaN gets exponent 255;
  - in every case the fraction is register bits 51..29.
- R4: On a single store of a double-tagged normal with biased exponent e ≤ 896, the result has the sign and exponent field 0. Its fraction is the 24-bit value {1, bits 51..29} shifted right by 897−e and kept to 23 bits.
- R5: In the R4 case, a shift of 24 or more gives a zero fraction (e = 873 gives ±0), while e = 874 gives fraction 1.
- R6: On a single store of a double-tagged normal with e > 896 (and e ≤ 1150), the exponent is e−896 and the fraction is bits 51..29. Lower bits are dropped by truncation.
- R7: On a single store of a double-tagged denormal, the result is a zero that keeps the operand's sign.
- R8: On a single store of a double-tagged zero, infinity, quiet NaN or signalling NaN, the result is the sign with exponent 0 and fraction 0 for a zero. For the other three classes it is the sign with exponent 255 and fraction bits 51..29, so an SNaN stays signalling.
- R9: On a double store of a single-tagged denormal, the output is normalized. With p the position of the highest set fraction bit, the exponent becomes 845+p and the fraction is shifted left by 52−p and cut to 52 bits.
- R10: On a double store, every other operand is written unchanged.
- R11: For a single store, the result sits in `out_data[31:0]` with `out_data[63:32]` zero. `out_dbl` repeats the store-kind bit of the operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Block can take an operand |
| in_value | input | 64 | Register operand in double layout |
| in_is_single | input | 1 | 1: value is exactly representable as single |
| in_dbl_store | input | 1 | 1: double store, 0: single store |
| out_valid | output | 1 | Store data present |
| out_ready | input | 1 | Consumer takes store data |
| out_data | output | 64 | Store data (single result in bits 31..0) |
| out_dbl | output | 1 | Store kind of this result |

## Verification
Each result is due exactly one edge after its operand is accepted. With the output ready, it is visible at the falling edge that follows the accepting edge and is taken at the next rising edge. The scoreboard records the falling-edge count at acceptance for every item. For items sent while the output is ready, it requires the pop to happen at the next falling edge. During an output stall, latency is not checked; the bench instead checks that the input is refused and that order and values survive the stall.

// File: rtl/fpst_pkg.sv
package fpst_pkg;
  typedef enum logic [2:0] {
    CLS_ZERO,
    CLS_DENORM,
    CLS_NORMAL,
    CLS_INF,
    CLS_QNAN,
    CLS_SNAN
  } fp_class_e;
endpackage

// File: rtl/fpst_classify.sv
module fpst_classify #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W-1:0]     exp_i,
  input  logic [FRAC_W-1:0]    frac_i,
  output fpst_pkg::fp_class_e  cls_o
);
  import fpst_pkg::*;

  logic exp_zero, exp_ones, frac_zero;

  assign exp_zero  = (exp_i == '0);
  assign exp_ones  = (exp_i == '1);
  assign frac_zero = (frac_i == '0);

  always_comb begin
    if (exp_zero)       cls_o = frac_zero ? CLS_ZERO : CLS_DENORM;
    else if (!exp_ones) cls_o = CLS_NORMAL;
    else if (frac_zero) cls_o = CLS_INF;
    else if (frac_i[FRAC_W-1]) cls_o = CLS_QNAN;
    else                cls_o = CLS_SNAN;
  end
endmodule

// File: rtl/fpst_to_single.sv
module fpst_to_single #(
  parameter int EXP_W    = 11,
  parameter int FRAC_W   = 52,
  parameter int S_EXP_W  = 8,
  parameter int S_FRAC_W = 23
) (
  input  logic                   sign_i,
  input  logic [EXP_W-1:0]       exp_i,
  input  logic [FRAC_W-1:0]      frac_i,
  input  fpst_pkg::fp_class_e    cls_i,
  input  logic                   is_single_i,
  output logic [S_EXP_W+S_FRAC_W:0] data_o
);
  import fpst_pkg::*;

  localparam int BIAS_DIFF = (1 << (EXP_W-1)) - (1 << (S_EXP_W-1));
  localparam int MANT_W    = S_FRAC_W + 1;

  logic [S_FRAC_W-1:0] top_frac;
  logic [MANT_W-1:0]   mant, shifted;
  logic [EXP_W-1:0]    sh_amt, rebiased;
  logic                too_small;
  logic [S_FRAC_W-1:0] tiny_frac;

  assign top_frac  = frac_i[FRAC_W-1 -: S_FRAC_W];
  assign mant      = {1'b1, top_frac};
  assign too_small = (exp_i <= EXP_W'(BIAS_DIFF));
  assign sh_amt    = EXP_W'(BIAS_DIFF + 1) - exp_i;
  assign shifted   = mant >> sh_amt;
  assign tiny_frac = (sh_amt >= EXP_W'(MANT_W)) ? '0 : shifted[S_FRAC_W-1:0];
  assign rebiased  = exp_i - EXP_W'(BIAS_DIFF);

  always_comb begin
    unique case (cls_i)
      CLS_ZERO:   data_o = {sign_i, {S_EXP_W{1'b0}}, {S_FRAC_W{1'b0}}};
      CLS_DENORM: data_o = is_single_i ? {sign_i, {S_EXP_W{1'b0}}, top_frac}
                                       : {sign_i, {S_EXP_W{1'b0}}, {S_FRAC_W{1'b0}}};
      CLS_NORMAL: begin
        if (!is_single_i && too_small)
          data_o = {sign_i, {S_EXP_W{1'b0}}, tiny_frac};
        else
          data_o = {sign_i, rebiased[S_EXP_W-1:0], top_frac};
      end
      default:    data_o = {sign_i, {S_EXP_W{1'b1}}, top_frac};
    endcase
  end
endmodule

// File: rtl/fpst_to_double.sv
module fpst_to_double #(
  parameter int EXP_W    = 11,
  parameter int FRAC_W   = 52,
  parameter int S_EXP_W  = 8
) (
  input  logic [EXP_W+FRAC_W:0]  value_i,
  input  fpst_pkg::fp_class_e    cls_i,
  input  logic                   is_single_i,
  output logic [EXP_W+FRAC_W:0]  data_o
);
  import fpst_pkg::*;

  localparam int BIAS_DIFF = (1 << (EXP_W-1)) - (1 << (S_EXP_W-1));
  localparam int POS_W     = $clog2(FRAC_W + 1);

  logic [FRAC_W-1:0] frac;
  logic [POS_W-1:0]  lead_pos, norm_sh;
  logic [FRAC_W-1:0] norm_frac;
  logic [EXP_W-1:0]  norm_exp;

  assign frac = value_i[FRAC_W-1:0];

  always_comb begin
    lead_pos = '0;
    for (int i = 0; i < FRAC_W; i++) begin
      if (frac[i]) lead_pos = POS_W'(i);
    end
  end

  assign norm_sh   = POS_W'(FRAC_W) - lead_pos;
  assign norm_frac = frac << norm_sh;
  assign norm_exp  = EXP_W'(BIAS_DIFF + 1) - EXP_W'(norm_sh);

  always_comb begin
    if (is_single_i && cls_i == CLS_DENORM)
      data_o = {value_i[EXP_W+FRAC_W], norm_exp, norm_frac};
    else
      data_o = value_i;
  end
endmodule

// File: rtl/fp_store_fmt.sv
module fp_store_fmt #(
  parameter int EXP_W    = 11,
  parameter int FRAC_W   = 52,
  parameter int S_EXP_W  = 8,
  parameter int S_FRAC_W = 23
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [EXP_W+FRAC_W:0]       in_value,
  input  logic                        in_is_single,
  input  logic                        in_dbl_store,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [EXP_W+FRAC_W:0]       out_data,
  output logic                        out_dbl
);
  import fpst_pkg::*;

  localparam int D_W = 1 + EXP_W + FRAC_W;
  localparam int S_W = 1 + S_EXP_W + S_FRAC_W;

  fp_class_e      cls;
  logic [S_W-1:0] single_res;
  logic [D_W-1:0] double_res, next_data;
  logic           accept;

  fpst_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
    .exp_i  (in_value[D_W-2 -: EXP_W]),
    .frac_i (in_value[FRAC_W-1:0]),
    .cls_o  (cls)
  );

  fpst_to_single #(.EXP_W(EXP_W), .FRAC_W(FRAC_W),
                   .S_EXP_W(S_EXP_W), .S_FRAC_W(S_FRAC_W)) u_sgl (
    .sign_i      (in_value[D_W-1]),
    .exp_i       (in_value[D_W-2 -: EXP_W]),
    .frac_i      (in_value[FRAC_W-1:0]),
    .cls_i       (cls),
    .is_single_i (in_is_single),
    .data_o      (single_res)
  );

  fpst_to_double #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .S_EXP_W(S_EXP_W)) u_dbl (
    .value_i     (in_value),
    .cls_i       (cls),
    .is_single_i (in_is_single),
    .data_o      (double_res)
  );

  assign in_ready  = !out_valid || out_ready;
  assign accept    = in_valid && in_ready;
  assign next_data = in_dbl_store ? double_res : {{(D_W-S_W){1'b0}}, single_res};

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_data <= '0;
      out_dbl  <= 1'b0;
    end else if (accept) begin
      out_data <= next_data;
      out_dbl  <= in_dbl_store;
    end
  end
endmodule

// File: rtl/fpst_checker.sv
module fpst_checker #(
  parameter int EXP_W    = 11,
  parameter int FRAC_W   = 52,
  parameter int S_EXP_W  = 8,
  parameter int S_FRAC_W = 23
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic [EXP_W+FRAC_W:0] in_value,
  input logic                  in_is_single,
  input logic                  in_dbl_store,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [EXP_W+FRAC_W:0] out_data,
  input logic                  out_dbl
);
  localparam int D_W = 1 + EXP_W + FRAC_W;
  localparam int S_W = 1 + S_EXP_W + S_FRAC_W;

  p_reset_clears_r1: assert property (@(posedge clk) rst |=> !out_valid);

  p_ready_when_empty_r2: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

  p_result_next_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  p_stall_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_dbl)));

  p_double_pass_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_dbl_store && !in_is_single)
      |=> (out_dbl && out_data == $past(in_value)));

  p_upper_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_dbl) |-> (out_data[D_W-1:S_W] == '0));

  p_kind_echo_r11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (out_dbl == $past(in_dbl_store)));
endmodule

bind fp_store_fmt fpst_checker #(
  .EXP_W(EXP_W), .FRAC_W(FRAC_W), .S_EXP_W(S_EXP_W), .S_FRAC_W(S_FRAC_W)
) u_fpst_checker (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_value(in_value), .in_is_single(in_is_single), .in_dbl_store(in_dbl_store),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_dbl(out_dbl)
);

// File: tb/test_fp_store_fmt.sv
module test_fp_store_fmt;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_value = '0;
  logic        in_is_single = 1'b0;
  logic        in_dbl_store = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;
  logic        out_dbl;

  typedef struct {
    logic [63:0] data;
    logic        dbl;
    int          acc;
    bit          lat;
    string       req;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fp_store_fmt i_fp_store_fmt (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_value(in_value), .in_is_single(in_is_single), .in_dbl_store(in_dbl_store),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_dbl(out_dbl)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Called just after a rising edge; returns just after the accepting edge.
  task automatic send(input logic [63:0] v, input bit st, input bit dbl,
                      input logic [63:0] exp, input string req);
    item_t it;
    in_value = v; in_is_single = st; in_dbl_store = dbl; in_valid = 1'b1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    it.lat = out_ready;
    @(posedge clk);
    it.data = dbl ? exp : {32'h0, exp[31:0]};
    it.dbl = dbl; it.acc = cyc; it.req = req;
    q.push_back(it);
    #1;
  endtask

  // Monitor: scoreboard pop at falling edges
  always @(negedge clk) begin
    cyc++;
    if (!rst && out_valid && out_ready) begin
      if (q.size() == 0) begin
        check(0, "R2", "unexpected result", out_data, 64'h0);
      end else begin
        item_t it;
        it = q.pop_front();
        check(out_data == it.data && out_dbl == it.dbl, it.req, "store data",
              {out_data[62:0], out_dbl}, {it.data[62:0], it.dbl});
        if (it.lat)
          check(cyc == it.acc + 1, "R2", "latency", 64'(cyc), 64'(it.acc + 1));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid in reset", 64'(out_valid), 64'h0);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R1", "state after reset",
          {62'h0, out_valid, in_ready}, 64'h1);
    @(posedge clk); #1;

    // R3: single store, single-tagged operands
    send(64'h3FF0000000000000, 1, 0, 64'h3F800000, "R3");
    send(64'hC004000000000000, 1, 0, 64'hC0200000, "R3");
    send(64'h0008000000000000, 1, 0, 64'h00400000, "R3");
    send(64'h7FF0000000000000, 1, 0, 64'h7F800000, "R3");
    send(64'h7FF4000000000000, 1, 0, 64'h7FA00000, "R3");
    // R4 / R5: denormalize too-small doubles
    send(64'h3800000000000000, 0, 0, 64'h00400000, "R4");
    send(64'hB700000000000000, 0, 0, 64'h80000040, "R4");
    send(64'h36A0000000000000, 0, 0, 64'h00000001, "R5");
    send(64'h3690000000000000, 0, 0, 64'h00000000, "R5");
    // R6: plain conversion
    send(64'h3818000000000000, 0, 0, 64'h00C00000, "R6");
    send(64'h3FF0000000000001, 0, 0, 64'h3F800000, "R6");
    // R7 / R8
    send(64'h8000000000000001, 0, 0, 64'h80000000, "R7");
    send(64'h7FF8000000000000, 0, 0, 64'h7FC00000, "R8");
    send(64'hFFF4000000000000, 0, 0, 64'hFFA00000, "R8");
    send(64'h8000000000000000, 0, 0, 64'h80000000, "R8");
    // R9: normalize single denormals on double store
    send(64'h0008000000000000, 1, 1, 64'h3800000000000000, "R9");
    send(64'h0000000020000000, 1, 1, 64'h36A0000000000000, "R9");
    send(64'h8006000000000000, 1, 1, 64'hB7F8000000000000, "R9");
    // R10 / R11: unchanged double stores and kind echo
    send(64'h400921FB54442D18, 0, 1, 64'h400921FB54442D18, "R10");
    send(64'h3FF0000000000000, 1, 1, 64'h3FF0000000000000, "R10");
    send(64'h7FF4000000000000, 0, 1, 64'h7FF4000000000000, "R11");
    in_valid = 1'b0;
    repeat (3) @(posedge clk); #1;

    // R2: back-pressure
    out_ready = 1'b0;
    fork
      begin
        send(64'h4000000000000000, 0, 0, 64'h40000000, "R2");
        send(64'hC000000000000000, 0, 1, 64'hC000000000000000, "R2");
        in_valid = 1'b0;
      end
      begin
        repeat (3) @(negedge clk);
        check(out_valid && !in_ready, "R2", "input refused during stall",
              {62'h0, out_valid, in_ready}, 64'h2);
        check(out_data == 64'h40000000, "R2", "held data during stall",
              out_data, 64'h40000000);
        @(posedge clk); #1 out_ready = 1'b1;
      end
    join
    repeat (4) @(posedge clk);
    check(q.size() == 0, "R2", "all results delivered", 64'(q.size()), 64'h0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule